// File: doc/BRIEF.md
# Series-Switch Leg Gate Sequencer

This block drives the four gate enables of one inverter phase leg built from four power switches stacked in series. Bit 0 is the upper outer switch, bit 1 the upper inner switch, bit 2 the lower inner switch and bit 3 the lower outer switch. Two command inputs ask for the upper path (bits 0 and 1 on) or the lower path (bits 2 and 3 on). With neither command asserted, the leg rests with every switch off.

In sequenced mode a step machine moves the leg one switch at a time. Each switch turns on only when its neighbours are in a safe state, and every step is held for a minimum number of clocks (`DWELL`). This keeps any one switch from carrying the whole bus voltage. In simultaneous mode each pair follows its command directly, which gives a faster transition. The mode is taken from `sim_req` only while the leg is fully off. Asserting both commands at once is refused: the leg holds its state and a fault flag is raised.

The states, with their enable patterns written as bit 3..0, are:

| State | Pattern |
|---|---|
| `ST_OFF` | 0000 |
| `ST_UP_IN` | 0010 |
| `ST_UP` | 0011 |
| `ST_MID` | 0110 |
| `ST_LO_IN` | 0100 |
| `ST_LO` | 1100 |

The sequenced transitions are:

- OFF→UP_IN→UP (turn-on of the upper path)
- OFF→LO_IN→LO (turn-on of the lower path)
- UP→UP_IN→OFF or →MID (leaving the upper path)
- LO→LO_IN→OFF or →MID (leaving the lower path)
- MID→UP_IN toward the upper path or to reach off
- MID→LO_IN toward the lower path
- UP_IN→UP
- LO_IN→LO

In simultaneous mode the machine jumps directly between OFF, UP and LO.

Top module: `leg_gate_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, all four gate enables and `cmd_fault` are cleared, and `sim_active` takes the value of `sim_req`.
- R2: In sequenced mode, bit 0 turns on only at an edge where `cmd_hi` is high and bit 2 was off.
- R3: In sequenced mode, bit 1 turns on only where bit 3 was off, and either bit 2 was off or `cmd_hi` is high.
- R4: In sequenced mode, bit 2 turns on only where bit 0 was off, and either bit 1 was off or `cmd_lo` is high.
- R5: In sequenced mode, bit 3 turns on only at an edge where `cmd_lo` is high and bit 1 was off.
- R6: At most two enables are on at once, and never bits 0 and 2 together, nor bits 1 and 3 together, in either mode.
- R7: In sequenced mode, each clock changes at most one enable. The leg follows the state graph above toward the target: 0011 for `cmd_hi`, 1100 for `cmd_lo`, 0000 for neither.
- R8: In simultaneous mode, bits 0 and 1 move together and bits 2 and 3 move together, going directly to the target pattern.
- R9: After the enables change, the new pattern is held for at least `DWELL` clocks before the next change.
- R10: When both commands are high at an edge, the enables keep their value and `cmd_fault` is high in the following cycle. `cmd_fault` is low otherwise.
- R11: `sim_active` changes only at an edge where all four enables were off.
- R12: With both commands low, the leg settles to 0000. In sequenced mode it leaves the lower path via 0100, and leaves the middle state 0110 via 0010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_hi | input | 1 | Request for upper conduction path |
| cmd_lo | input | 1 | Request for lower conduction path |
| sim_req | input | 1 | Requested mode: 1 simultaneous, 0 sequenced |
| gate_en | output | 4 | Gate enables, bit 0 upper outer … bit 3 lower outer |
| sim_active | output | 1 | Mode in force: 1 simultaneous, 0 sequenced |
| cmd_fault | output | 1 | Both commands were high at the last edge |

## Verification
Every result of this block is due exactly one clock after the edge that samples its cause:

- the next enable pattern,
- the fault flag,
- the mode in force.

After the enables change, the next change comes no earlier than `DWELL` edges later. The bench changes the inputs at a falling edge. It advances its own path model for the rising edge that follows, and compares all three outputs at the next falling edge, so every comparison lands one register stage after its stimulus. Start and end commands are swept in every combination, with both mode values, followed by a long pseudo-random stretch of short command pulses. Dwell and ordering rules are checked on each cycle against the previous outputs.

// File: rtl/leg_seq_pkg.sv
package leg_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_UP,
        ST_UP_IN,
        ST_MID,
        ST_LO_IN,
        ST_LO
    } leg_state_t;

    typedef enum logic [1:0] {
        TGT_OFF,
        TGT_UP,
        TGT_LO,
        TGT_BAD
    } leg_target_t;

endpackage

// File: rtl/leg_target_decode.sv
module leg_target_decode
    import leg_seq_pkg::*;
(
    input  logic        cmd_hi,
    input  logic        cmd_lo,
    output leg_target_t tgt
);

    always_comb begin
        unique case ({cmd_hi, cmd_lo})
            2'b10:   tgt = TGT_UP;
            2'b01:   tgt = TGT_LO;
            2'b11:   tgt = TGT_BAD;
            default: tgt = TGT_OFF;
        endcase
    end

endmodule

// File: rtl/leg_dwell_timer.sv
module leg_dwell_timer #(
    parameter int DWELL = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic moved,
    output logic ready
);

    localparam int CW = (DWELL > 1) ? $clog2(DWELL) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(DWELL - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (moved) begin
            cnt_q <= RELOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign ready = (cnt_q == '0);

endmodule

// File: rtl/leg_step_fsm.sv
module leg_step_fsm
    import leg_seq_pkg::*;
(
    input  leg_state_t  state_q,
    input  leg_target_t tgt,
    input  logic        ready,
    input  logic        sim,
    output leg_state_t  state_d
);

    always_comb begin
        state_d = state_q;
        if (tgt == TGT_BAD || !ready) begin
            state_d = state_q;
        end else if (sim) begin
            unique case (tgt)
                TGT_UP:  state_d = ST_UP;
                TGT_LO:  state_d = ST_LO;
                default: state_d = ST_OFF;
            endcase
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    if (tgt == TGT_UP)      state_d = ST_UP_IN;
                    else if (tgt == TGT_LO) state_d = ST_LO_IN;
                    else                    state_d = ST_OFF;
                end
                ST_UP: begin
                    state_d = (tgt == TGT_UP) ? ST_UP : ST_UP_IN;
                end
                ST_UP_IN: begin
                    if (tgt == TGT_UP)      state_d = ST_UP;
                    else if (tgt == TGT_LO) state_d = ST_MID;
                    else                    state_d = ST_OFF;
                end
                ST_MID: begin
                    state_d = (tgt == TGT_LO) ? ST_LO_IN : ST_UP_IN;
                end
                ST_LO_IN: begin
                    if (tgt == TGT_LO)      state_d = ST_LO;
                    else if (tgt == TGT_UP) state_d = ST_MID;
                    else                    state_d = ST_OFF;
                end
                ST_LO: begin
                    state_d = (tgt == TGT_LO) ? ST_LO : ST_LO_IN;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

endmodule

// File: rtl/leg_gate_sequencer.sv
module leg_gate_sequencer
    import leg_seq_pkg::*;
#(
    parameter int DWELL = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_hi,
    input  logic       cmd_lo,
    input  logic       sim_req,
    output logic [3:0] gate_en,
    output logic       sim_active,
    output logic       cmd_fault
);

    leg_state_t  state_q;
    leg_state_t  state_d;
    leg_target_t tgt;
    logic        ready;
    logic        mode_q;
    logic        fault_q;
    logic        eff_sim;

    // The mode may only be swapped while the whole leg is off.
    assign eff_sim = (state_q == ST_OFF) ? sim_req : mode_q;

    leg_target_decode u_dec (
        .cmd_hi (cmd_hi),
        .cmd_lo (cmd_lo),
        .tgt    (tgt)
    );

    leg_dwell_timer #(.DWELL(DWELL)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .moved (state_d != state_q),
        .ready (ready)
    );

    leg_step_fsm u_fsm (
        .state_q (state_q),
        .tgt     (tgt),
        .ready   (ready),
        .sim     (eff_sim),
        .state_d (state_d)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF;
            mode_q  <= sim_req;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            mode_q  <= eff_sim;
            fault_q <= (tgt == TGT_BAD);
        end
    end

    // Outputs decoded from the registered state
    always_comb begin
        unique case (state_q)
            ST_UP:    gate_en = 4'b0011;
            ST_UP_IN: gate_en = 4'b0010;
            ST_MID:   gate_en = 4'b0110;
            ST_LO_IN: gate_en = 4'b0100;
            ST_LO:    gate_en = 4'b1100;
            default:  gate_en = 4'b0000;
        endcase
    end

    assign sim_active = mode_q;
    assign cmd_fault  = fault_q;

endmodule

// File: rtl/leg_seq_chk.sv
module leg_seq_chk #(
    parameter int DWELL = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       cmd_hi,
    input logic       cmd_lo,
    input logic [3:0] gate_en,
    input logic       sim_active,
    input logic       cmd_fault
);

    localparam int AW = $clog2(DWELL + 1);

    logic [3:0]    prev_g;
    logic [AW-1:0] age;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_g <= 4'b0000;
            age    <= AW'(DWELL);
        end else begin
            prev_g <= gate_en;
            if (gate_en != prev_g) begin
                age <= AW'(1);
            end else if (age < AW'(DWELL)) begin
                age <= age + AW'(1);
            end
        end
    end

    // R2
    q1_turn_on_chk: assert property (@(posedge clk) disable iff (rst)
        (!sim_active && $rose(gate_en[0])) |-> ($past(cmd_hi) && !$past(gate_en[2])));

    // R3
    q2_turn_on_chk: assert property (@(posedge clk) disable iff (rst)
        (!sim_active && $rose(gate_en[1])) |->
            (!$past(gate_en[3]) && (!$past(gate_en[2]) || $past(cmd_hi))));

    // R4
    q3_turn_on_chk: assert property (@(posedge clk) disable iff (rst)
        (!sim_active && $rose(gate_en[2])) |->
            (!$past(gate_en[0]) && (!$past(gate_en[1]) || $past(cmd_lo))));

    // R5
    q4_turn_on_chk: assert property (@(posedge clk) disable iff (rst)
        (!sim_active && $rose(gate_en[3])) |-> ($past(cmd_lo) && !$past(gate_en[1])));

    // R6
    max_two_on_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(gate_en) <= 2) && !(gate_en[0] && gate_en[2]) && !(gate_en[1] && gate_en[3]));

    // R7
    one_step_chk: assert property (@(posedge clk) disable iff (rst)
        !sim_active |-> ($countones(gate_en ^ $past(gate_en)) <= 1));

    // R8
    pairs_move_chk: assert property (@(posedge clk) disable iff (rst)
        sim_active |-> ((gate_en[0] == gate_en[1]) && (gate_en[2] == gate_en[3])));

    // R9
    dwell_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_en != prev_g) |-> (age >= AW'(DWELL)));

    // R10
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(cmd_hi && cmd_lo) |-> $stable(gate_en));

    // R10
    fault_flag_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_fault == $past(cmd_hi && cmd_lo));

    // R11
    mode_swap_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sim_active) |-> ($past(gate_en) == 4'b0000));

endmodule

bind leg_gate_sequencer leg_seq_chk #(.DWELL(DWELL)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .cmd_hi     (cmd_hi),
    .cmd_lo     (cmd_lo),
    .gate_en    (gate_en),
    .sim_active (sim_active),
    .cmd_fault  (cmd_fault)
);

// File: tb/leg_gate_sequencer_tb_top.sv
module leg_gate_sequencer_tb_top;

    localparam int DW = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_hi = 1'b0;
    logic       cmd_lo = 1'b0;
    logic       sim_req = 1'b0;
    logic [3:0] gate_en;
    logic       sim_active;
    logic       cmd_fault;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    // model state
    logic [3:0] m_g;
    int         m_cnt;
    logic       m_mode;
    logic       m_err;
    // previous observed outputs
    logic [3:0] p_g;
    logic       p_mode;
    int         run;

    always #2 clk = ~clk;

    leg_gate_sequencer #(.DWELL(DW)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .cmd_hi     (cmd_hi),
        .cmd_lo     (cmd_lo),
        .sim_req    (sim_req),
        .gate_en    (gate_en),
        .sim_active (sim_active),
        .cmd_fault  (cmd_fault)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // positions along the sequenced path: 0 upper, 4 lower
    function automatic logic [3:0] pat(input int p);
        case (p)
            0: return 4'b0011;
            1: return 4'b0010;
            2: return 4'b0110;
            3: return 4'b0100;
            default: return 4'b1100;
        endcase
    endfunction

    function automatic int pos(input logic [3:0] g);
        for (int i = 0; i < 5; i++) if (pat(i) == g) return i;
        return -1;
    endfunction

    function automatic logic [3:0] seq_next(input logic [3:0] cur, input logic [3:0] tgt);
        int pc;
        int pt;
        if (cur == tgt) return cur;
        pc = pos(cur);
        if (tgt == 4'b0000) begin
            if (pc == 1 || pc == 3) return 4'b0000;
            if (pc == 4) return pat(3);
            return pat(1);
        end
        pt = pos(tgt);
        if (cur == 4'b0000) return pat(pt == 0 ? 1 : 3);
        return pat(pt > pc ? pc + 1 : pc - 1);
    endfunction

    task automatic tick(input logic hi, input logic lo, input logic sr);
        logic       both;
        logic       eff;
        logic [3:0] tgt;
        logic [3:0] nxt;
        cmd_hi  = hi;
        cmd_lo  = lo;
        sim_req = sr;
        both = hi & lo;
        eff  = (m_g == 4'b0000) ? sr : m_mode;
        tgt  = both ? m_g : (hi ? 4'b0011 : (lo ? 4'b1100 : 4'b0000));
        nxt  = (both || m_cnt != 0) ? m_g : (eff ? tgt : seq_next(m_g, tgt));
        if (nxt != m_g) m_cnt = DW - 1;
        else if (m_cnt > 0) m_cnt = m_cnt - 1;
        m_mode = eff;
        m_err  = both;
        m_g    = nxt;
        @(negedge clk);
        // model comparisons
        chk(gate_en == m_g, m_mode ? "R8 gates" : "R7 R12 gates", gate_en, m_g);
        chk(cmd_fault == m_err, "R10 fault", cmd_fault, m_err);
        chk(sim_active == m_mode, "R11 mode", sim_active, m_mode);
        // rule checks against previous outputs
        chk($countones(gate_en) <= 2 && !(gate_en[0] && gate_en[2]) && !(gate_en[1] && gate_en[3]),
            "R6 overlap", gate_en, 0);
        if (!sim_active) begin
            if (gate_en[0] && !p_g[0]) chk(hi && !p_g[2], "R2 q1 on", {hi, p_g[2]}, 2);
            if (gate_en[1] && !p_g[1]) chk(!p_g[3] && (!p_g[2] || hi), "R3 q2 on", p_g, 0);
            if (gate_en[2] && !p_g[2]) chk(!p_g[0] && (!p_g[1] || lo), "R4 q3 on", p_g, 0);
            if (gate_en[3] && !p_g[3]) chk(lo && !p_g[1], "R5 q4 on", {lo, p_g[1]}, 2);
        end else begin
            chk(gate_en[0] == gate_en[1] && gate_en[2] == gate_en[3], "R8 pairs", gate_en, 0);
        end
        if (both) chk(gate_en == p_g, "R10 hold", gate_en, p_g);
        if (sim_active != p_mode) chk(p_g == 4'b0000, "R11 swap", p_g, 0);
        if (gate_en != p_g) begin
            chk(run >= DW, "R9 dwell", run, DW);
            run = 1;
        end else begin
            run++;
        end
        p_g    = gate_en;
        p_mode = sim_active;
    endtask

    task automatic do_reset(input logic sr);
        rst     = 1'b1;
        cmd_hi  = 1'b1;
        cmd_lo  = 1'b0;
        sim_req = sr;
        @(negedge clk);
        @(negedge clk);
        chk(gate_en == 4'b0000, "R1 gates", gate_en, 0);
        chk(cmd_fault == 1'b0, "R1 fault", cmd_fault, 0);
        chk(sim_active == sr, "R1 mode", sim_active, sr);
        m_g = 4'b0000; m_cnt = 0; m_mode = sr; m_err = 1'b0;
        p_g = 4'b0000; p_mode = sr; run = DW;
        cmd_hi = 1'b0;
        rst = 1'b0;
    endtask

    initial begin
        logic [15:0] lfsr;
        @(negedge clk);
        do_reset(1'b1);
        do_reset(1'b0);
        // sweep: start/end commands and modes
        for (int m0 = 0; m0 < 2; m0++)
            for (int m1 = 0; m1 < 2; m1++)
                for (int c0 = 0; c0 < 4; c0++)
                    for (int c1 = 0; c1 < 4; c1++) begin
                        for (int k = 0; k < 12; k++) tick(c0[1], c0[0], m0[0]);
                        for (int k = 0; k < 12; k++) tick(c1[1], c1[0], m1[0]);
                        if (c1 == 0) chk(gate_en == 4'b0000, "R12 idle", gate_en, 0);
                        for (int k = 0; k < 12; k++) tick(1'b0, 1'b0, m1[0]);
                    end
        // pseudo-random short pulses
        lfsr = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            int len;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            len  = 1 + int'(lfsr[3:2]) + int'(lfsr[5:4]);
            for (int k = 0; k < len; k++) tick(lfsr[0], lfsr[1], lfsr[8] & lfsr[9]);
        end
        for (int k = 0; k < 20; k++) tick(1'b0, 1'b0, 1'b0);
        chk(gate_en == 4'b0000, "R12 final idle", gate_en, 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule